// File: doc/BRIEF.md
# Statechart Microstep Transition Selector

This block carries out one microstep of a hierarchical statechart in hardware. Each state owns one bit of an activity vector, so an active atomic state, its ancestors and all regions of a parallel state can be active together. The chart's shape and transitions are fixed at elaboration through parameter masks:
- each state's parent, kind and default child;
- each transition's source, the events it responds to, the lower-priority transitions it conflicts with, the states it leaves and the states it targets.

On each cycle the block looks at the current activity, the event strobes and a phase flag. It picks a set of transitions that can fire together and derives the states to exit and the states to enter. When the step input is high it loads the new activity vector on the clock edge. The surrounding controller runs eventless phases (phase flag high) until nothing is selected, then presents one event per phase (flag low). It uses the event-consumed pulse to retire that event.

Top module: `stc_microstep`

## Requirements
- R1: A transition flagged eventless (bit t of `EVENTLESS` = 1) can be selected only while `spont_i` is 1. Any other transition can be selected only while `spont_i` is 0.
- R2: Transition t is selected only if state `SRC[t]` (field t of `SRC`, `IDXW` bits wide) is active in `act_o`.
- R3: An event-driven transition t matches when any strobe in `event_i` is set whose bit is also set in its slice of `EV_MASK` (bit e of slice t means event e fits one of t's name prefixes; all ones is the wildcard). An eventless transition always matches.
- R4: Transitions are ranked by index, with 0 the highest priority. Transition t is dropped when some lower-indexed j with bit j of t's `CONFLICT` row set is selected. `sel_o` bit t shows the selection.
- R5: `exit_o` bit s is 1 exactly when state s is active and some selected transition has bit s set in its `EXIT_MASK` row.
- R6: `entry_up_o` bit s is 1 when a selected transition has bit s set in its `TARGET` row. A compound state's bit is also 1 when any of its children's bits is 1.
- R7: The complete entry set holds every state in the upward entry set. It also holds every child of a parallel state that is itself in the complete set. It also holds the default child (`DEFAULT_CHILD`) of a compound parent p, but only when all three hold: p is in the complete set, none of p's children is in the upward set, and none of p's children is active without also being exited.
- R8: A synchronous reset loads `INIT_ACT` into `act_o`. On a clock edge with `step_i` = 1, `act_o` becomes (act AND NOT exit) OR complete entry set. With `step_i` = 0, `act_o` holds its value.
- R9: `consumed_o` is 1 for the cycle after an edge where `step_i` = 1, `spont_i` = 0 and at least one event-driven transition is selected. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step_i | input | 1 | Commit the microstep on this edge |
| spont_i | input | 1 | Phase flag: 1 = eventless phase, 0 = event phase |
| event_i | input | N_EVENTS | Event strobes, one bit per event name |
| sel_o | output | N_TRANS | Selected transition set |
| exit_o | output | N_STATES | Exit set |
| entry_up_o | output | N_STATES | Upward entry set |
| act_o | output | N_STATES | Registered activity vector |
| consumed_o | output | 1 | Event consumed pulse |

## Verification
The test chart has a root with three children: an atomic state, a compound state with two atomic children, and a parallel state with a compound region and an atomic region.

- Directed steps: these trigger a prefix-matched event, an eventless move inside the compound state, a wildcard transition into the parallel state, and a same-event collision between the two regions. The collision shows whether priority suppression works or both transitions leak through. The directed steps also include an eventless phase on a state that has only event-driven transitions.
- Held step: a step with `step_i` low shows whether selection alone can disturb the activity vector.
- Random phase: a long run of mixed phase flags, event combinations and step gaps follows. Every cycle it is compared with a behavioural model of the selection, exit and entry rules. This separates default-child entry into the parallel regions from direct targeting of a sibling.

// File: rtl/stc_pkg.sv
package stc_pkg;

   typedef enum logic [1:0] {
      KIND_ATOMIC   = 2'd0,
      KIND_COMPOUND = 2'd1,
      KIND_PARALLEL = 2'd2
   } stc_kind_e;

   function automatic stc_kind_e kind_of(input logic is_comp, input logic is_par);
      if (is_par)       return KIND_PARALLEL;
      else if (is_comp) return KIND_COMPOUND;
      else              return KIND_ATOMIC;
   endfunction

endpackage

// File: rtl/stc_select.sv
module stc_select #(
   parameter int N_STATES = 10,
   parameter int N_TRANS  = 6,
   parameter int N_EVENTS = 3,
   parameter int IDXW     = 4,
   parameter logic [N_TRANS*IDXW-1:0]     SRC       = '0,
   parameter logic [N_TRANS-1:0]          EVENTLESS = '0,
   parameter logic [N_TRANS*N_EVENTS-1:0] EV_MASK   = '0,
   parameter logic [N_TRANS*N_TRANS-1:0]  CONFLICT  = '0
) (
   input  logic [N_STATES-1:0] act_i,
   input  logic                spont_i,
   input  logic [N_EVENTS-1:0] event_i,
   output logic [N_TRANS-1:0]  sel_o
);

   // Priority chain: lower index decided first, later ones see it.
   always_comb begin
      logic match, phase_ok, blocked;
      logic [IDXW-1:0] src;
      sel_o = '0;
      for (int t = 0; t < N_TRANS; t++) begin
         src      = SRC[t*IDXW +: IDXW];
         match    = EVENTLESS[t] | (|(event_i & EV_MASK[t*N_EVENTS +: N_EVENTS]));
         phase_ok = EVENTLESS[t] ? spont_i : ~spont_i;
         blocked  = 1'b0;
         for (int j = 0; j < t; j++) begin
            if (CONFLICT[t*N_TRANS + j] && sel_o[j]) blocked = 1'b1;
         end
         sel_o[t] = phase_ok & act_i[src] & match & ~blocked;
      end
   end

endmodule

// File: rtl/stc_sets.sv
module stc_sets
   import stc_pkg::*;
#(
   parameter int N_STATES = 10,
   parameter int N_TRANS  = 6,
   parameter int IDXW     = 4,
   parameter logic [N_STATES*IDXW-1:0]    PARENT        = '0,
   parameter logic [N_STATES-1:0]         COMPOUND      = '0,
   parameter logic [N_STATES-1:0]         PARALLEL      = '0,
   parameter logic [N_STATES-1:0]         DEFAULT_CHILD = '0,
   parameter logic [N_TRANS*N_STATES-1:0] EXIT_MASK     = '0,
   parameter logic [N_TRANS*N_STATES-1:0] TARGET        = '0
) (
   input  logic [N_STATES-1:0] act_i,
   input  logic [N_TRANS-1:0]  sel_i,
   output logic [N_STATES-1:0] exit_o,
   output logic [N_STATES-1:0] up_o,
   output logic [N_STATES-1:0] full_o
);

   logic [N_STATES-1:0] kid_stays;
   logic [N_STATES-1:0] kid_up;

   // Exit set: active states named by a selected transition's exit row.
   always_comb begin
      logic hit;
      for (int s = 0; s < N_STATES; s++) begin
         hit = 1'b0;
         for (int t = 0; t < N_TRANS; t++) hit |= sel_i[t] & EXIT_MASK[t*N_STATES + s];
         exit_o[s] = act_i[s] & hit;
      end
   end

   // Upward set: children carry a higher index, so walk downward.
   always_comb begin
      logic u;
      up_o = '0;
      for (int s = N_STATES - 1; s >= 0; s--) begin
         u = 1'b0;
         for (int t = 0; t < N_TRANS; t++) u |= sel_i[t] & TARGET[t*N_STATES + s];
         if (kind_of(COMPOUND[s], PARALLEL[s]) == KIND_COMPOUND) begin
            for (int c = s + 1; c < N_STATES; c++) begin
               if (int'(PARENT[c*IDXW +: IDXW]) == s) u |= up_o[c];
            end
         end
         up_o[s] = u;
      end
   end

   // Per-parent summaries of the children.
   always_comb begin
      logic [IDXW-1:0] p;
      kid_stays = '0;
      kid_up    = '0;
      for (int c = 1; c < N_STATES; c++) begin
         p = PARENT[c*IDXW +: IDXW];
         if (act_i[c] && !exit_o[c]) kid_stays[p] = 1'b1;
         if (up_o[c])                kid_up[p]    = 1'b1;
      end
   end

   // Complete entry set: parents carry a lower index, so walk upward.
   always_comb begin
      logic [IDXW-1:0] p;
      logic f;
      full_o    = '0;
      full_o[0] = up_o[0];
      for (int s = 1; s < N_STATES; s++) begin
         p = PARENT[s*IDXW +: IDXW];
         f = up_o[s];
         case (kind_of(COMPOUND[p], PARALLEL[p]))
            KIND_PARALLEL: f |= full_o[p];
            KIND_COMPOUND: f |= DEFAULT_CHILD[s] & full_o[p] & ~kid_up[p] & ~kid_stays[p];
            default:       f |= 1'b0;
         endcase
         full_o[s] = f;
      end
   end

endmodule

// File: rtl/stc_microstep.sv
module stc_microstep #(
   parameter int N_STATES = 10,
   parameter int N_TRANS  = 6,
   parameter int N_EVENTS = 3,
   parameter int IDXW     = $clog2(N_STATES),
   parameter logic [N_STATES*IDXW-1:0] PARENT =
      {4'd6, 4'd6, 4'd3, 4'd3, 4'd2, 4'd2, 4'd0, 4'd0, 4'd0, 4'd0},
   parameter logic [N_STATES-1:0] COMPOUND      = 10'h045,
   parameter logic [N_STATES-1:0] PARALLEL      = 10'h008,
   parameter logic [N_STATES-1:0] DEFAULT_CHILD = 10'h112,
   parameter logic [N_STATES-1:0] INIT_ACT      = 10'h003,
   parameter logic [N_TRANS*IDXW-1:0] SRC = {4'd7, 4'd8, 4'd2, 4'd5, 4'd1, 4'd1},
   parameter logic [N_TRANS-1:0] EVENTLESS = 6'b000100,
   parameter logic [N_TRANS*N_EVENTS-1:0] EV_MASK =
      {3'b010, 3'b011, 3'b111, 3'b000, 3'b100, 3'b011},
   parameter logic [N_TRANS*N_TRANS-1:0] CONFLICT =
      {6'b010000, 6'b000000, 6'b000100, 6'b000000, 6'b000001, 6'b000000},
   parameter logic [N_TRANS*N_STATES-1:0] EXIT_MASK =
      {10'h3C8, 10'h100, 10'h034, 10'h020, 10'h002, 10'h002},
   parameter logic [N_TRANS*N_STATES-1:0] TARGET =
      {10'h002, 10'h200, 10'h008, 10'h010, 10'h008, 10'h020}
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                step_i,
   input  logic                spont_i,
   input  logic [N_EVENTS-1:0] event_i,
   output logic [N_TRANS-1:0]  sel_o,
   output logic [N_STATES-1:0] exit_o,
   output logic [N_STATES-1:0] entry_up_o,
   output logic [N_STATES-1:0] act_o,
   output logic                consumed_o
);

   // Elaboration checks on the chart description.
   if (N_STATES < 2) begin : g_bad_states
      $error("stc_microstep: N_STATES must be at least 2");
   end
   if (N_TRANS < 1 || N_EVENTS < 1) begin : g_bad_counts
      $error("stc_microstep: N_TRANS and N_EVENTS must be positive");
   end
   if (IDXW < $clog2(N_STATES)) begin : g_bad_idxw
      $error("stc_microstep: IDXW too narrow for N_STATES");
   end
   if ((COMPOUND & PARALLEL) != '0) begin : g_bad_kind
      $error("stc_microstep: a state cannot be compound and parallel");
   end
   for (genvar s = 1; s < N_STATES; s++) begin : g_chk_parent
      if (int'(PARENT[s*IDXW +: IDXW]) >= s) begin : g_order
         $error("stc_microstep: parent index must precede child index");
      end
   end
   for (genvar t = 0; t < N_TRANS; t++) begin : g_chk_src
      if (int'(SRC[t*IDXW +: IDXW]) >= N_STATES) begin : g_range
         $error("stc_microstep: transition source out of range");
      end
   end

   logic [N_STATES-1:0] act_q;
   logic [N_STATES-1:0] full_set;
   logic                consumed_q;

   stc_select #(
      .N_STATES(N_STATES), .N_TRANS(N_TRANS), .N_EVENTS(N_EVENTS), .IDXW(IDXW),
      .SRC(SRC), .EVENTLESS(EVENTLESS), .EV_MASK(EV_MASK), .CONFLICT(CONFLICT)
   ) u_select (
      .act_i(act_q), .spont_i(spont_i), .event_i(event_i), .sel_o(sel_o)
   );

   stc_sets #(
      .N_STATES(N_STATES), .N_TRANS(N_TRANS), .IDXW(IDXW),
      .PARENT(PARENT), .COMPOUND(COMPOUND), .PARALLEL(PARALLEL),
      .DEFAULT_CHILD(DEFAULT_CHILD), .EXIT_MASK(EXIT_MASK), .TARGET(TARGET)
   ) u_sets (
      .act_i(act_q), .sel_i(sel_o), .exit_o(exit_o), .up_o(entry_up_o), .full_o(full_set)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         act_q      <= INIT_ACT;
         consumed_q <= 1'b0;
      end else begin
         if (step_i) act_q <= (act_q & ~exit_o) | full_set;
         consumed_q <= step_i & ~spont_i & (|(sel_o & ~EVENTLESS));
      end
   end

   assign act_o      = act_q;
   assign consumed_o = consumed_q;

   // R1: selection respects the phase flag.
   p_phase_r1: assert property (@(posedge clk) disable iff (rst)
      spont_i |-> ((sel_o & ~EVENTLESS) == '0));
   p_phase_ev_r1: assert property (@(posedge clk) disable iff (rst)
      !spont_i |-> ((sel_o & EVENTLESS) == '0));

   for (genvar t = 0; t < N_TRANS; t++) begin : g_prop_t
      // R2: a selected transition has an active source.
      p_source_r2: assert property (@(posedge clk) disable iff (rst)
         sel_o[t] |-> act_q[SRC[t*IDXW +: IDXW]]);
      // R4: no selected transition coexists with a higher-priority conflicting one.
      p_conflict_r4: assert property (@(posedge clk) disable iff (rst)
         sel_o[t] |-> ((sel_o & CONFLICT[t*N_TRANS +: N_TRANS] & N_TRANS'((1 << t) - 1)) == '0));
   end

   // R5: only active states can be exited.
   p_exit_active_r5: assert property (@(posedge clk) disable iff (rst)
      (exit_o & ~act_q) == '0);

   // R8: a cycle without a step leaves the configuration untouched.
   p_hold_r8: assert property (@(posedge clk) disable iff (rst)
      !step_i |=> $stable(act_o));

   // R9: the consumed pulse only follows an event-phase step.
   p_consume_r9: assert property (@(posedge clk) disable iff (rst)
      !step_i |=> !consumed_o);

endmodule

// File: tb/stc_microstep_tb.sv
module stc_microstep_tb;

   localparam int NS = 10;
   localparam int NT = 6;
   localparam int NE = 3;

   logic          clk = 1'b0;
   logic          rst;
   logic          step_i;
   logic          spont_i;
   logic [NE-1:0] event_i;
   logic [NT-1:0] sel_o;
   logic [NS-1:0] exit_o, entry_up_o, act_o;
   logic          consumed_o;

   always #10 clk = ~clk;

   stc_microstep u_dut (
      .clk(clk), .rst(rst), .step_i(step_i), .spont_i(spont_i), .event_i(event_i),
      .sel_o(sel_o), .exit_o(exit_o), .entry_up_o(entry_up_o), .act_o(act_o),
      .consumed_o(consumed_o)
   );

   // Test chart: 0 root, 1 A, 2 C{4 C1*,5 C2}, 3 P||{6 Q{8 Q1*,9 Q2}, 7 R}
   // Events: 0 "go", 1 "go.fast", 2 "stop".
   int par   [NS] = '{0, 0, 0, 0, 2, 2, 3, 3, 6, 6};
   int kind  [NS] = '{1, 0, 1, 2, 0, 0, 1, 0, 0, 0}; // 0 atomic 1 compound 2 parallel
   int dflt  [NS] = '{0, 1, 0, 0, 1, 0, 0, 0, 1, 0};
   int src   [NT] = '{1, 1, 5, 2, 8, 7};
   int noev  [NT] = '{0, 0, 1, 0, 0, 0};
   int evs   [NT] = '{3, 4, 0, 7, 3, 2};
   int conf  [NT] = '{0, 1, 0, 4, 0, 16};
   int leave [NT] = '{'h002, 'h002, 'h020, 'h034, 'h100, 'h3C8};
   int dest  [NT] = '{'h020, 'h008, 'h010, 'h008, 'h200, 'h002};

   int vectors = 0;
   int miscompares = 0;
   bit done = 0;

   logic [NS-1:0] m_act;
   logic          m_cons;
   logic [NT-1:0] m_sel;
   logic [NS-1:0] m_exit, m_up, m_full;

   task automatic model_eval();
      m_sel = '0;
      for (int t = 0; t < NT; t++) begin
         bit ok;
         ok = m_act[src[t]];
         if (noev[t] != 0) ok = ok && spont_i;
         else ok = ok && !spont_i && ((int'(event_i) & evs[t]) != 0);
         for (int j = 0; j < t; j++)
            if (((conf[t] >> j) & 1) != 0 && m_sel[j]) ok = 0;
         m_sel[t] = ok;
      end
      m_exit = '0;
      m_up   = '0;
      for (int t = 0; t < NT; t++) begin
         if (m_sel[t]) begin
            m_exit |= NS'(leave[t]);
            m_up   |= NS'(dest[t]);
         end
      end
      m_exit &= m_act;
      for (int s = NS - 1; s >= 0; s--)
         if (kind[s] == 1)
            for (int c = 1; c < NS; c++)
               if (par[c] == s && m_up[c]) m_up[s] = 1'b1;
      m_full = m_up;
      for (int s = 1; s < NS; s++) begin
         int p;
         p = par[s];
         if (kind[p] == 2 && m_full[p]) m_full[s] = 1'b1;
         if (kind[p] == 1 && dflt[s] != 0 && m_full[p]) begin
            bit busy;
            busy = 0;
            for (int c = 1; c < NS; c++)
               if (par[c] == p && (m_up[c] || (m_act[c] && !m_exit[c]))) busy = 1;
            if (!busy) m_full[s] = 1'b1;
         end
      end
   endtask

   task automatic cmp(input string tag, input logic [15:0] got, input logic [15:0] exp);
      if (got !== exp) begin
         miscompares++;
         $display("FAIL %s at vector %0d: got %h expected %h", tag, vectors, got, exp);
      end
   endtask

   task automatic apply(input logic sp, input logic [NE-1:0] ev, input logic st);
      @(negedge clk);
      spont_i = sp;
      event_i = ev;
      step_i  = st;
      #1;
      model_eval();
      vectors++;
      cmp("R1 R2 R3 R4 selected set", 16'(sel_o), 16'(m_sel));
      cmp("R5 exit set", 16'(exit_o), 16'(m_exit));
      cmp("R6 upward entry set", 16'(entry_up_o), 16'(m_up));
      cmp("R7 R8 activity", 16'(act_o), 16'(m_act));
      cmp("R9 consumed", 16'(consumed_o), 16'(m_cons));
      @(posedge clk);
      #1;
      m_cons = st & ~sp & (|(m_sel & ~NT'(6'b000100)));
      if (st) m_act = (m_act & ~m_exit) | m_full;
   endtask

   initial begin
      rst = 1'b1; step_i = 1'b0; spont_i = 1'b0; event_i = '0;
      m_act = NS'(10'h003);
      m_cons = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      vectors++;
      cmp("R8 reset activity", 16'(act_o), 16'h0003);
      cmp("R9 reset consumed", 16'(consumed_o), 16'h0000);

      apply(1'b1, 3'b000, 1'b1); // R1: eventless phase, A has no eventless exit
      apply(1'b0, 3'b001, 1'b0); // R8: t0 selected but step held
      apply(1'b0, 3'b001, 1'b1); // R3: "go" -> C2
      cmp("R6 entered C2", 16'(act_o), 16'h0025);
      apply(1'b1, 3'b000, 1'b1); // R1: eventless C2 -> C1
      cmp("R5 C2 left for C1", 16'(act_o), 16'h0015);
      apply(1'b0, 3'b100, 1'b1); // R3 wildcard C -> P, R7 defaults Q1 and R
      cmp("R7 parallel entry", 16'(act_o), 16'h01C9);
      apply(1'b0, 3'b010, 1'b1); // R4: Q1 (go prefix) beats R (go.fast)
      cmp("R4 priority kept R", 16'(act_o), 16'h02C9);
      apply(1'b0, 3'b010, 1'b1); // R2: Q2 has no exit, R fires back to A
      cmp("R2 back to A", 16'(act_o), 16'h0003);

      for (int i = 0; i < 400; i++) begin
         apply(1'($urandom_range(0, 1)), 3'($urandom_range(0, 7)),
               1'($urandom_range(0, 3) != 0));
      end
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

endmodule